// File: doc/BRIEF.md
# Three-Level PWM Gate Sequencer

This block drives one synchronous buck phase from a PWM command that has three levels. An analog front end has already sorted the PWM pin into high, low or the middle window, and it presents that result as a two-bit code. The block turns the code into two gate enables, one for the high-side switch and one for the low-side switch. It first qualifies each level against a minimum persistence. It then holds every accepted high or low command for a minimum width, so a narrow pulse is stretched rather than lost. A middle-window level turns both switches off, but only after a hold-off that depends on whether the command was high or low before. Every switch-over runs through a break-before-make sequence.

The low-side switch can be kept off by an active-low disable input. The pad that carries this signal has a pull-up outside the block, so an undriven pin reads as 1. A separate input reports that the high-side gate has discharged, and this sets the adaptive dead time from high to low. In the other direction a fixed dead time, counted in clock cycles, separates the end of the low-side enable from the start of the high-side enable. A global enable input stands in for supply supervision. While it is low, both gates are held off and the whole decode pipeline is cleared. Every timing figure is a parameter in clock cycles.

Top module: `tristate_pwm_gate`

## Requirements
- R1: After reset, `gh` and `gl` are 0 and `tri_st` is 1, and they stay that way until `en` is high and a level has been qualified.
- R2: `pwm_lvl` encodes 2'b00 as low, 2'b01 as high, and both 2'b10 and 2'b11 as the middle window. A code is accepted only after it has been sampled DET_CYC times in a row, so a shorter excursion changes no output.
- R3: While the accepted command is high, `gh` becomes 1 and `gl` stays 0, whatever `ls_off_n` is.
- R4: While the accepted command is low and `ls_off_n` is 1, `gl` becomes 1. When `ls_off_n` is 0, `gl` goes to 0 one cycle after the sample and stays 0.
- R5: A middle-window level clears both gates and sets `tri_st`. The level must first have been seen for TS_LO_CYC qualified cycles if the command was low, or TS_HI_CYC if it was high. A shorter middle excursion leaves the gates unchanged. Counted from the first sampling edge, a driven gate stays on for DET_CYC+TS cycles.
- R6: An accepted high or low command is held for at least MIN_CYC cycles before any other command replaces it. A high pulse lasting DET_CYC samples, set inside a steady low, therefore produces exactly one cycle of `gh`.
- R7: On a change from high to low, `gh` drops first. `gl` rises only after `hs_dis` has been sampled at 1 with `gh` already off, followed by SEC_CYC further cycles. When `hs_dis` is already 1, `gl` rises DET_CYC+3+SEC_CYC samples after the low code is first applied.
- R8: On a change from low to high, `gh` rises only after `gl` has been 0 for DT_CYC cycles. From a steady low, `gh` rises DET_CYC+2+DT_CYC samples after the high code is first applied.
- R9: `gh` and `gl` are never 1 in the same cycle.
- R10: When `en` is sampled at 0, both gates are 0 from the next cycle onward and `tri_st` is 1. After `en` returns, the command must be qualified again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Global enable; low forces both gates off and clears the pipeline |
| pwm_lvl | input | 2 | Pre-decoded PWM level: 00 low, 01 high, 10/11 middle window |
| ls_off_n | input | 1 | Active-low low-side disable (pad pull-up keeps it 1 when undriven) |
| hs_dis | input | 1 | High-side gate discharged indication |
| gh | output | 1 | High-side gate enable |
| gl | output | 1 | Low-side gate enable |
| tri_st | output | 1 | Both gates released because of the middle window, enable or reset |

## Verification
Each internal count shows up at the ports as a gate edge that is a whole number of cycles early or late. A qualifier that is off by one moves every rising and falling edge by one cycle. A hold-off counter that loads the wrong limit shortens or lengthens how long a gate stays on after the middle-window code appears. A sequencer that skips its wait state makes a gate rise in the same cycle as its partner falls, or lets `gl` rise while `hs_dis` is still low. Because every one of these faults moves an edge, a cycle-accurate comparison of `gh`, `gl` and `tri_st` finds a corrupted state at the first transition that passes through it, within a few cycles of the stimulus.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  // Decoded command level; the middle code also means "both gates released"
  typedef enum logic [1:0] {
    LVL_LO  = 2'b00,
    LVL_HI  = 2'b01,
    LVL_MID = 2'b10
  } lvl_e;

  // Break-before-make sequencer states
  typedef enum logic [2:0] {
    SQ_OFF   = 3'd0,
    SQ_DT    = 3'd1,
    SQ_HS    = 3'd2,
    SQ_DISCH = 3'd3,
    SQ_SEC   = 3'd4,
    SQ_LS    = 3'd5
  } seq_e;

  function automatic lvl_e decode_lvl(input logic [1:0] code);
    lvl_e r;
    case (code)
      2'b00:   r = LVL_LO;
      2'b01:   r = LVL_HI;
      default: r = LVL_MID;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tsp_level_qual.sv
module tsp_level_qual
  import tsp_pkg::*;
#(
  parameter int unsigned DET_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic [1:0] code_i,
  output lvl_e       lvl_o
);

  localparam int unsigned RW = $clog2(DET_CYC + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(DET_CYC);
  localparam logic [RW-1:0] RUN_ONE = RW'(1);

  lvl_e          last_q, last_d;
  lvl_e          lvl_q, lvl_d;
  lvl_e          dec;
  logic [RW-1:0] run_q, run_d;

  // next state: count identical consecutive samples, accept at the threshold
  always_comb begin
    dec    = decode_lvl(code_i);
    last_d = dec;
    if (dec == last_q) begin
      run_d = (run_q == RUN_MAX) ? run_q : run_q + RUN_ONE;
    end else begin
      run_d = RUN_ONE;
    end
    lvl_d = (run_d >= RUN_MAX) ? dec : lvl_q;
    if (clr_i) begin
      last_d = LVL_MID;
      run_d  = '0;
      lvl_d  = LVL_MID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LVL_MID;
      run_q  <= '0;
      lvl_q  <= LVL_MID;
    end else begin
      last_q <= last_d;
      run_q  <= run_d;
      lvl_q  <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/tsp_cmd_shaper.sv
module tsp_cmd_shaper
  import tsp_pkg::*;
#(
  parameter int unsigned MIN_CYC   = 3,
  parameter int unsigned TS_LO_CYC = 4,
  parameter int unsigned TS_HI_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  lvl_e lvl_i,
  output lvl_e cmd_o
);

  localparam int unsigned TS_MAX = (TS_LO_CYC > TS_HI_CYC) ? TS_LO_CYC : TS_HI_CYC;
  localparam int unsigned AW     = $clog2(MIN_CYC + 1);
  localparam int unsigned MW     = $clog2(TS_MAX + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(MIN_CYC);
  localparam logic [AW-1:0] AGE_ONE = AW'(1);
  localparam logic [MW-1:0] MID_MAX = MW'(TS_MAX);
  localparam logic [MW-1:0] MID_ONE = MW'(1);
  localparam logic [MW-1:0] LIM_LO  = MW'(TS_LO_CYC);
  localparam logic [MW-1:0] LIM_HI  = MW'(TS_HI_CYC);

  lvl_e          cmd_q, cmd_d;
  logic [AW-1:0] age_q, age_d, age_inc;
  logic [MW-1:0] mid_q, mid_d, mid_lim;
  logic          aged;

  // minimum-width gate: trivially met when the minimum is a single cycle
  generate
    if (MIN_CYC <= 1) begin : g_no_min
      assign aged = 1'b1;
    end else begin : g_min
      assign aged = (age_q >= AGE_MAX);
    end
  endgenerate

  always_comb begin
    age_inc = (age_q == AGE_MAX) ? age_q : age_q + AGE_ONE;
    if (lvl_i == LVL_MID) begin
      mid_d = (mid_q == MID_MAX) ? mid_q : mid_q + MID_ONE;
    end else begin
      mid_d = '0;
    end
    mid_lim = (cmd_q == LVL_LO) ? LIM_LO : LIM_HI;
    cmd_d   = cmd_q;
    age_d   = age_inc;
    if (lvl_i != LVL_MID) begin
      if ((lvl_i != cmd_q) && ((cmd_q == LVL_MID) || aged)) begin
        cmd_d = lvl_i;
        age_d = AGE_ONE;
      end
    end else if ((cmd_q != LVL_MID) && (mid_d >= mid_lim) && aged) begin
      cmd_d = LVL_MID;
      age_d = AGE_ONE;
    end
    if (clr_i) begin
      cmd_d = LVL_MID;
      age_d = '0;
      mid_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= LVL_MID;
      age_q <= '0;
      mid_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      age_q <= age_d;
      mid_q <= mid_d;
    end
  end

  assign cmd_o = cmd_q;

endmodule

// File: rtl/tsp_bbm_seq.sv
module tsp_bbm_seq
  import tsp_pkg::*;
#(
  parameter int unsigned SEC_CYC = 2,
  parameter int unsigned DT_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  lvl_e cmd_i,
  input  logic ls_off_n_i,
  input  logic hs_dis_i,
  output logic gh_o,
  output logic gl_o
);

  localparam int unsigned CMAX = (SEC_CYC > DT_CYC) ? SEC_CYC : DT_CYC;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SEC_LAST = CW'(SEC_CYC - 1);
  localparam logic [CW-1:0] DT_LAST  = CW'(DT_CYC - 1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  seq_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          want_gh, want_gl;
  logic          gh_q, gl_q;

  always_comb begin
    want_gh = (cmd_i == LVL_HI);
    want_gl = (cmd_i == LVL_LO) && ls_off_n_i;
    st_d    = st_q;
    cnt_d   = cnt_q;
    case (st_q)
      SQ_OFF: begin
        if (want_gh) begin
          st_d  = SQ_DT;
          cnt_d = '0;
        end else if (want_gl) begin
          st_d = SQ_DISCH;
        end
      end
      SQ_HS: begin
        if (!want_gh) st_d = SQ_DISCH;
      end
      SQ_DISCH: begin
        if (want_gl) begin
          if (hs_dis_i) begin
            st_d  = SQ_SEC;
            cnt_d = '0;
          end
        end else if (want_gh) begin
          st_d  = SQ_DT;
          cnt_d = '0;
        end else begin
          st_d = SQ_OFF;
        end
      end
      SQ_SEC: begin
        if (want_gl) begin
          if (cnt_q == SEC_LAST) st_d = SQ_LS;
          else                   cnt_d = cnt_q + CNT_ONE;
        end else if (want_gh) begin
          st_d  = SQ_DT;
          cnt_d = '0;
        end else begin
          st_d = SQ_OFF;
        end
      end
      SQ_LS: begin
        if (!want_gl) begin
          st_d  = SQ_DT;
          cnt_d = '0;
        end
      end
      SQ_DT: begin
        if (want_gh) begin
          if (cnt_q == DT_LAST) st_d = SQ_HS;
          else                  cnt_d = cnt_q + CNT_ONE;
        end else if (want_gl) begin
          st_d = SQ_DISCH;
        end else begin
          st_d = SQ_OFF;
        end
      end
      default: begin
        st_d  = SQ_OFF;
        cnt_d = '0;
      end
    endcase
    if (clr_i) begin
      st_d  = SQ_OFF;
      cnt_d = '0;
    end
  end

  // gate flops load from the next state so the outputs are glitch free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_OFF;
      cnt_q <= '0;
      gh_q  <= 1'b0;
      gl_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      gh_q  <= (st_d == SQ_HS);
      gl_q  <= (st_d == SQ_LS);
    end
  end

  assign gh_o = gh_q;
  assign gl_o = gl_q;

endmodule

// File: rtl/tristate_pwm_gate.sv
module tristate_pwm_gate
  import tsp_pkg::*;
#(
  parameter int unsigned DET_CYC   = 2,
  parameter int unsigned MIN_CYC   = 3,
  parameter int unsigned TS_LO_CYC = 4,
  parameter int unsigned TS_HI_CYC = 6,
  parameter int unsigned SEC_CYC   = 2,
  parameter int unsigned DT_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] pwm_lvl,
  input  logic       ls_off_n,
  input  logic       hs_dis,
  output logic       gh,
  output logic       gl,
  output logic       tri_st
);

  localparam int unsigned SYNC_W = 2;

  logic [SYNC_W-1:0] rst_pipe;
  logic              rst_int_n;
  logic              clr;
  lvl_e              lvl_w;
  lvl_e              cmd_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_W-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_W-1];
  assign clr       = ~en;

  tsp_level_qual #(
    .DET_CYC (DET_CYC)
  ) u_qual (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (clr),
    .code_i (pwm_lvl),
    .lvl_o  (lvl_w)
  );

  tsp_cmd_shaper #(
    .MIN_CYC   (MIN_CYC),
    .TS_LO_CYC (TS_LO_CYC),
    .TS_HI_CYC (TS_HI_CYC)
  ) u_shape (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr_i (clr),
    .lvl_i (lvl_w),
    .cmd_o (cmd_w)
  );

  tsp_bbm_seq #(
    .SEC_CYC (SEC_CYC),
    .DT_CYC  (DT_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr_i      (clr),
    .cmd_i      (cmd_w),
    .ls_off_n_i (ls_off_n),
    .hs_dis_i   (hs_dis),
    .gh_o       (gh),
    .gl_o       (gl)
  );

  assign tri_st = (cmd_w == LVL_MID);

endmodule

// File: rtl/tristate_pwm_gate_chk.sv
module tristate_pwm_gate_chk #(
  parameter int unsigned SEC_CYC = 2,
  parameter int unsigned DT_CYC  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic ls_off_n,
  input logic hs_dis,
  input logic gh,
  input logic gl,
  input logic tri_st
);

  localparam int unsigned LIM = SEC_CYC + DT_CYC + 2;
  localparam int unsigned LW  = $clog2(LIM + 1);
  localparam logic [LW-1:0] CNT_MAX = LW'(LIM);
  localparam logic [LW-1:0] CNT_ONE = LW'(1);
  localparam logic [LW-1:0] SEC_MIN = LW'(SEC_CYC + 1);
  localparam logic [LW-1:0] DT_MIN  = LW'(DT_CYC);

  logic [LW-1:0] gh_low_cnt, gl_low_cnt;
  logic          disch_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gh_low_cnt <= '0;
      gl_low_cnt <= '0;
      disch_seen <= 1'b0;
    end else begin
      gh_low_cnt <= gh ? '0 : ((gh_low_cnt == CNT_MAX) ? gh_low_cnt : gh_low_cnt + CNT_ONE);
      gl_low_cnt <= gl ? '0 : ((gl_low_cnt == CNT_MAX) ? gl_low_cnt : gl_low_cnt + CNT_ONE);
      if (gh)                disch_seen <= 1'b0;
      else if (hs_dis)       disch_seen <= 1'b1;
    end
  end

  p_gate_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh && gl));

  p_enable_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gh && !gl));

  p_lsdis_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_off_n |=> !gl);

  p_tri_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tri_st |=> (!gh && !gl));

  p_dead_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh) |-> (gl_low_cnt >= DT_MIN));

  p_sec_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl) |-> (gh_low_cnt >= SEC_MIN));

  p_disch_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl) |-> disch_seen);

endmodule

bind tristate_pwm_gate tristate_pwm_gate_chk #(
  .SEC_CYC (SEC_CYC),
  .DT_CYC  (DT_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .ls_off_n (ls_off_n),
  .hs_dis   (hs_dis),
  .gh       (gh),
  .gl       (gl),
  .tri_st   (tri_st)
);

// File: tb/tristate_pwm_gate_tb_top.sv
module tristate_pwm_gate_tb_top;

  localparam int DET_CYC   = 2;
  localparam int MIN_CYC   = 3;
  localparam int TS_LO_CYC = 4;
  localparam int TS_HI_CYC = 6;
  localparam int SEC_CYC   = 2;
  localparam int DT_CYC    = 2;

  logic       clk = 1'b0;
  logic       rst_n, en, ls_off_n, hs_dis;
  logic [1:0] pwm;
  logic       gh, gl, tri_st;

  always #5 clk = ~clk;

  tristate_pwm_gate #(
    .DET_CYC(DET_CYC), .MIN_CYC(MIN_CYC), .TS_LO_CYC(TS_LO_CYC),
    .TS_HI_CYC(TS_HI_CYC), .SEC_CYC(SEC_CYC), .DT_CYC(DT_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_lvl(pwm),
    .ls_off_n(ls_off_n), .hs_dis(hs_dis), .gh(gh), .gl(gl), .tri_st(tri_st)
  );

  int    checks = 0;
  int    errors = 0;
  int    both_on = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";

  // reference model state: 0 low, 1 high, 2 middle/off
  int m_rs = 0, m_last = 2, m_run = 0, m_q = 2;
  int m_cmd = 2, m_age = 0, m_mid = 0;
  int m_st = 0, m_cnt = 0;   // 0 off,1 dead,2 hs,3 wait discharge,4 secondary,5 ls
  bit m_gh = 0, m_gl = 0, m_tri = 1;

  function automatic int code2lvl(input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b01) return 1;
    return 2;
  endfunction

  always @(posedge clk) begin
    int  d, lim, nmid;
    bit  wh, wl, clear;
    clear = 0;
    if (!rst_n) begin
      m_rs  = 0;
      clear = 1;
    end else if (m_rs < 2) begin
      m_rs++;
      clear = 1;
    end else if (!en) begin
      clear = 1;
    end
    if (clear) begin
      m_last = 2; m_run = 0; m_q = 2;
      m_cmd = 2; m_age = 0; m_mid = 0;
      m_st = 0; m_cnt = 0;
    end else begin
      wh = (m_cmd == 1);
      wl = (m_cmd == 0) && ls_off_n;
      case (m_st)
        0: if (wh) begin m_st = 1; m_cnt = 0; end else if (wl) m_st = 3;
        1: if (wh) begin
             if (m_cnt == DT_CYC - 1) m_st = 2; else m_cnt++;
           end else if (wl) m_st = 3; else m_st = 0;
        2: if (!wh) m_st = 3;
        3: if (wl) begin
             if (hs_dis) begin m_st = 4; m_cnt = 0; end
           end else if (wh) begin m_st = 1; m_cnt = 0; end else m_st = 0;
        4: if (wl) begin
             if (m_cnt == SEC_CYC - 1) m_st = 5; else m_cnt++;
           end else if (wh) begin m_st = 1; m_cnt = 0; end else m_st = 0;
        default: if (!wl) begin m_st = 1; m_cnt = 0; end
      endcase
      nmid = (m_q == 2) ? m_mid + 1 : 0;
      if (m_q != 2) begin
        if (m_q != m_cmd && (m_cmd == 2 || m_age >= MIN_CYC)) begin
          m_cmd = m_q; m_age = 1;
        end else m_age++;
      end else begin
        lim = (m_cmd == 0) ? TS_LO_CYC : TS_HI_CYC;
        if (m_cmd != 2 && nmid >= lim && m_age >= MIN_CYC) begin
          m_cmd = 2; m_age = 1;
        end else m_age++;
      end
      m_mid = nmid;
      d = code2lvl(pwm);
      if (d == m_last) m_run++; else m_run = 1;
      m_last = d;
      if (m_run >= DET_CYC) m_q = d;
    end
    m_gh  = (m_st == 2);
    m_gl  = (m_st == 5);
    m_tri = (m_cmd == 2);
  end

  task automatic step();
    @(negedge clk);
    if (gh && gl) both_on++;
    if (cmp_on) begin
      checks++;
      if (gh !== m_gh || gl !== m_gl || tri_st !== m_tri) begin
        errors++;
        $display("FAIL %s: gh/gl/tri actual %b%b%b expected %b%b%b at %0t",
                 cur_req, gh, gl, tri_st, m_gh, m_gl, m_tri, $time);
      end
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 0; en = 0; pwm = 2'b10; ls_off_n = 1; hs_dis = 1;
    repeat (3) step();
    check("R1", "gh in reset", gh, 0);
    check("R1", "gl in reset", gl, 0);
    check("R1", "tri_st in reset", tri_st, 1);
    rst_n = 1; cmp_on = 1;
    repeat (4) step();
    check("R1", "tri_st with enable low", tri_st, 1);

    // R3: high command
    en = 1; cur_req = "R3"; pwm = 2'b01;
    repeat (12) step();
    check("R3", "gh on high", gh, 1);
    check("R3", "gl on high", gl, 0);
    ls_off_n = 0;
    repeat (4) step();
    check("R3", "gh with low-side disabled", gh, 1);
    ls_off_n = 1;

    // R7: high to low waits for discharge indication
    cur_req = "R7"; hs_dis = 0; pwm = 2'b00;
    repeat (10) step();
    check("R7", "gl before discharge", gl, 0);
    check("R7", "gh after low command", gh, 0);
    hs_dis = 1; n = 0;
    forever begin step(); n++; if (gl || n > 20) break; end
    check("R7", "samples from discharge to gl", n, SEC_CYC + 1);

    // R4: low-side disable
    cur_req = "R4";
    repeat (3) step();
    check("R4", "gl on low", gl, 1);
    ls_off_n = 0; step();
    check("R4", "gl one cycle after disable", gl, 0);
    repeat (3) step();
    check("R4", "gl held off", gl, 0);
    check("R4", "gh held off", gh, 0);
    ls_off_n = 1;
    repeat (6) step();
    check("R4", "gl after disable released", gl, 1);

    // R2: short glitches ignored
    cur_req = "R2"; n = 0;
    pwm = 2'b01; step(); if (gh) n++;
    pwm = 2'b00; repeat (6) begin step(); if (gh || !gl) n++; end
    pwm = 2'b11; step(); if (!gl) n++;
    pwm = 2'b00; repeat (6) begin step(); if (gh || !gl) n++; end
    check("R2", "cycles disturbed by glitches", n, 0);

    // R6: narrow high pulse stretched
    cur_req = "R6"; n = 0;
    pwm = 2'b01; repeat (DET_CYC) step();
    pwm = 2'b00; repeat (15) begin step(); if (gh) n++; end
    check("R6", "gh cycles from stretched pulse", n, 1);

    // R8: low to high latency
    cur_req = "R8"; n = 0; pwm = 2'b01;
    forever begin step(); n++; if (gh || n > 30) break; end
    check("R8", "samples to gh", n, DET_CYC + 2 + DT_CYC);
    repeat (6) step();

    // R7: high to low latency with discharge already reported
    cur_req = "R7"; n = 0; pwm = 2'b00;
    forever begin step(); n++; if (gl || n > 30) break; end
    check("R7", "samples to gl", n, DET_CYC + 3 + SEC_CYC);
    repeat (6) step();

    // R5: hold-off from low, short excursion, hold-off from high
    cur_req = "R5"; n = 0;
    pwm = 2'b10; repeat (3) begin step(); if (!gl) n++; end
    pwm = 2'b00; repeat (6) begin step(); if (!gl) n++; end
    check("R5", "gl drops on short middle excursion", n, 0);
    n = 0; pwm = 2'b10;
    forever begin step(); if (!gl || n > 40) break; n++; end
    check("R5", "gl cycles after middle from low", n, DET_CYC + TS_LO_CYC);
    check("R5", "tri_st after hold-off", tri_st, 1);
    pwm = 2'b01; repeat (14) step();
    n = 0; pwm = 2'b11;
    forever begin step(); if (!gh || n > 40) break; n++; end
    check("R5", "gh cycles after middle from high", n, DET_CYC + TS_HI_CYC);

    // R10: enable
    cur_req = "R10"; pwm = 2'b01;
    repeat (14) step();
    en = 0; step();
    check("R10", "gh after enable low", gh, 0);
    check("R10", "tri_st after enable low", tri_st, 1);
    en = 1;
    repeat (12) step();
    check("R10", "gh after enable restored", gh, 1);

    // R9: mixed stimulus compared against the model every cycle
    cur_req = "R9";
    for (int i = 0; i < 400; i++) begin
      pwm      = 2'($urandom_range(0, 3));
      ls_off_n = ($urandom_range(0, 7) != 0);
      hs_dis   = ($urandom_range(0, 3) != 0);
      en       = ($urandom_range(0, 31) != 0);
      repeat ($urandom_range(1, 9)) step();
    end
    en = 1; ls_off_n = 1; hs_dis = 1;
    repeat (10) step();
    check("R9", "cycles with both gates on", both_on, 0);

    finish_run();
  end

endmodule